// File: doc/BRIEF.md
# HDLC FIFO Status and Event Register

This block assembles one 8-bit status byte for the host side of an HDLC controller. Four of its bits are sticky event flags. They latch one-cycle pulses from the receive and transmit framing engines and from a loop-code detector. The other four bits are live level flags. They are computed every cycle from the occupancy counts of the receive FIFO and the transmit FIFO, which are each 64 bytes deep by default.

The host reads the byte through a read strobe. While the strobe is high, the read data shows the current value, including any sticky bits that are set. At the clock edge that ends the strobe, the sticky bits clear. An event pulse that arrives in the same cycle as the strobe wins over the clear, so no event is lost. The receive end-of-frame flag gathers four causes into one bit: a good frame finishing after its CRC check, a CRC error, a receive overrun and a detected abort.

Top module: `hdlc_stat_reg`

## Requirements
- R1: After reset, all sticky bits (2, 3, 6, 7) read 0. With both FIFO counts at 0, the byte reads 0x03.
- R2: Bit positions are fixed as follows: bit0 transmit space available, bit1 transmit below half, bit2 frame-start seen, bit3 frame-end seen, bit4 receive data available, bit5 receive above half, bit6 transmit message done, bit7 loop-code event.
- R3: Bit4 is 1 exactly when the receive count is at least 1.
- R4: Bit5 is 1 exactly when the receive count is greater than DEPTH/2 (32 by default).
- R5: Bit1 is 1 exactly when the transmit count is less than DEPTH/2.
- R6: Bit0 is 1 exactly when the transmit count is less than DEPTH.
- R7: A pulse on `rx_start_ev` sets bit2 from the next cycle on. The bit stays set until it is cleared by a read.
- R8: Bit3 sets in the cycle after a pulse on any one of `rx_done_ev`, `rx_crc_err_ev`, `rx_ovr_ev` or `rx_abort_ev`.
- R9: A pulse on `tx_done_ev` sets bit6, and a pulse on `loop_ev` sets bit7, each from the next cycle on.
- R10: While `rd_stb` is high, `rd_data` shows the pre-clear value. Sticky bits that received no event in that cycle read 0 from the following cycle on.
- R11: An event pulse in the same cycle as `rd_stb` leaves its sticky bit set after the read.
- R12: A read does not change bits 0, 1, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start_ev | input | 1 | Opening byte of a frame detected |
| rx_done_ev | input | 1 | Good frame finished with its CRC check complete |
| rx_crc_err_ev | input | 1 | Frame ended with a CRC error |
| rx_ovr_ev | input | 1 | Receive overrun |
| rx_abort_ev | input | 1 | Abort detected |
| tx_done_ev | input | 1 | Transmit engine finished a message |
| loop_ev | input | 1 | Loop-code event |
| rx_count | input | CW | Receive FIFO occupancy, 0..DEPTH |
| tx_count | input | CW | Transmit FIFO occupancy, 0..DEPTH |
| rd_stb | input | 1 | Host read strobe; clears the sticky bits |
| rd_data | output | 8 | Status byte |

## Verification
The bench builds the block with its default DEPTH of 64. The count width is therefore 7 bits, and every occupancy from empty to full can be driven. This puts the exact threshold edges within reach: receive counts 32 and 33, transmit counts 31 and 32, and transmit counts 63 and 64. Directed sequences cover each end-of-frame cause on its own, the value returned during the read strobe, and an event that collides with a read.

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start_ev,
  input  logic          rx_done_ev,
  input  logic          rx_crc_err_ev,
  input  logic          rx_ovr_ev,
  input  logic          rx_abort_ev,
  input  logic          tx_done_ev,
  input  logic          loop_ev,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rd_stb,
  output logic [7:0]    rd_data
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic rx_sof_q, rx_eof_q, tx_eom_q, loop_q;
  logic rx_end_hit;

  assign rx_end_hit = rx_done_ev | rx_crc_err_ev | rx_ovr_ev | rx_abort_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sof_q <= 1'b0;
      rx_eof_q <= 1'b0;
      tx_eom_q <= 1'b0;
      loop_q   <= 1'b0;
    end else begin
      rx_sof_q <= rx_start_ev | (rx_sof_q & ~rd_stb);
      rx_eof_q <= rx_end_hit  | (rx_eof_q & ~rd_stb);
      tx_eom_q <= tx_done_ev  | (tx_eom_q & ~rd_stb);
      loop_q   <= loop_ev     | (loop_q   & ~rd_stb);
    end
  end

  assign rd_data = {loop_q,
                    tx_eom_q,
                    rx_count > HALF,
                    rx_count != '0,
                    rx_eof_q,
                    rx_sof_q,
                    tx_count < HALF,
                    tx_count < FULL};
endmodule

module hdlc_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_start_ev,
  input logic       rx_done_ev,
  input logic       rx_crc_err_ev,
  input logic       rx_ovr_ev,
  input logic       rx_abort_ev,
  input logic       tx_done_ev,
  input logic       loop_ev,
  input logic       rd_stb,
  input logic [7:0] rd_data
);
  // R7
  sof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_ev |=> rd_data[2]);
  // R8
  eof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_ev | rx_crc_err_ev | rx_ovr_ev | rx_abort_ev) |=> rd_data[3]);
  // R9
  eom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_ev |=> rd_data[6]);
  // R9
  loop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_ev |=> rd_data[7]);
  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rx_start_ev && !rx_done_ev && !rx_crc_err_ev && !rx_ovr_ev
     && !rx_abort_ev && !tx_done_ev && !loop_ev) |=> (rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00));
  // R7
  sof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && rd_data[2]) |=> rd_data[2]);
endmodule

bind hdlc_stat_reg hdlc_stat_reg_chk i_chk (.*);

// File: tb/test_hdlc_stat_reg.sv
`timescale 1ns/1ps
module test_hdlc_stat_reg;
  localparam int CW = 7;
  localparam int NV = 8;
  localparam logic [CW-1:0] VRX [NV] = '{7'd0, 7'd1, 7'd32, 7'd33, 7'd64, 7'd0,  7'd63, 7'd32};
  localparam logic [CW-1:0] VTX [NV] = '{7'd0, 7'd0, 7'd31, 7'd32, 7'd64, 7'd63, 7'd1,  7'd64};
  localparam logic [7:0]    VEX [NV] = '{8'h03, 8'h13, 8'h13, 8'h31, 8'h30, 8'h01, 8'h33, 8'h10};

  logic clk = 0, rst_n = 0;
  logic rx_start_ev = 0, rx_done_ev = 0, rx_crc_err_ev = 0, rx_ovr_ev = 0, rx_abort_ev = 0;
  logic tx_done_ev = 0, loop_ev = 0, rd_stb = 0;
  logic [CW-1:0] rx_count = 0, tx_count = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hdlc_stat_reg i_hdlc_stat_reg (.*);

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, rd_data, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
    rx_start_ev = 0; rx_done_ev = 0; rx_crc_err_ev = 0; rx_ovr_ev = 0;
    rx_abort_ev = 0; tx_done_ev = 0; loop_ev = 0; rd_stb = 0;
  endtask

  task automatic do_read(input string req, input logic [7:0] pre, input logic [7:0] post);
    rd_stb = 1; #1;
    chk(req, pre);
    edge1();
    chk(req, post);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", 8'h03);

    for (int i = 0; i < NV; i++) begin
      rx_count = VRX[i]; tx_count = VTX[i]; #1;
      chk("R2 R3 R4 R5 R6", VEX[i]);
    end
    rx_count = 0; tx_count = 0; #1;

    rx_start_ev = 1; edge1(); chk("R7", 8'h07);
    edge1(); chk("R7", 8'h07);
    do_read("R10", 8'h07, 8'h03);

    rx_done_ev = 1; edge1(); chk("R8", 8'h0B); do_read("R8", 8'h0B, 8'h03);
    rx_crc_err_ev = 1; edge1(); chk("R8", 8'h0B); do_read("R8", 8'h0B, 8'h03);
    rx_ovr_ev = 1; edge1(); chk("R8", 8'h0B); do_read("R8", 8'h0B, 8'h03);
    rx_abort_ev = 1; edge1(); chk("R8", 8'h0B); do_read("R8", 8'h0B, 8'h03);

    tx_done_ev = 1; edge1(); chk("R9", 8'h43);
    loop_ev = 1; edge1(); chk("R9", 8'hC3);
    do_read("R10", 8'hC3, 8'h03);

    rx_start_ev = 1; edge1();
    rx_start_ev = 1; do_read("R11", 8'h07, 8'h07);
    rx_done_ev = 1; do_read("R11", 8'h07, 8'h0B);
    do_read("R10", 8'h0B, 8'h03);

    rx_count = 40; tx_count = 10;
    tx_done_ev = 1; edge1(); chk("R12", 8'h73);
    do_read("R12", 8'h73, 8'h33);

    rst_n = 0; rx_start_ev = 1; loop_ev = 1; @(posedge clk); #1;
    rx_start_ev = 0; loop_ev = 0; rx_count = 0; tx_count = 0; rst_n = 1; #1;
    chk("R1", 8'h03);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule